// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns pending exception requests into the write steps that move a 32-bit core into an exception handler. Seven request inputs are arbitrated each time the sequencer is idle: reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction and software interrupt. The two interrupt inputs are level-sensitive, and each is masked by its own disable bit in the live status word. The block does not hold the status register, the banked link registers or the program counter itself. It drives write strobes, with target mode and data, towards a register file that sits outside.

When a request is accepted, the block takes a copy of the live status word and of the return address offered on `ret_addr`. It then issues one write per cycle in a fixed order: the mode switch, the link register of the new mode, the saved-status register of the new mode, the updated status word, and finally the program counter loaded with the vector. The cycle that loads the program counter also carries a one-cycle completion pulse.

A reset request skips the link and saved-status writes. It also cuts short any other entry that is in progress.

Top module: `exc_entry_seq`

## Requirements
- R1: When several unmasked requests are sampled together, exactly one is taken. The order from highest to lowest is reset, data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, software interrupt.
- R2: The program counter write carries VECTOR_BASE plus an offset. The offsets are 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for interrupt and 0x1C for fast interrupt.
- R3: The mode write carries a 5-bit mode code. Reset and software interrupt use 10011. Both aborts use 10111. Undefined uses 11011. Interrupt uses 10010 and fast interrupt uses 10001.
- R4: The saved-status write carries the status word as it was sampled at acceptance, tagged with the new mode code.
- R5: The link write carries `ret_addr` as it was sampled at acceptance, tagged with the new mode code.
- R6: The status write carries the sampled word with three changes: bits [4:0] replaced by the new mode code, bit 7 (interrupt disable) set, and bit 5 (16-bit state) cleared. All other bits are kept, except as R7 states.
- R7: Bit 6 (fast interrupt disable) is set in the status write for fast interrupt and reset entries, and kept as sampled for every other entry.
- R8: An interrupt request is ignored while status bit 7 is 1, and a fast interrupt request is ignored while status bit 6 is 1. The other five requests are never masked.
- R9: The first strobe comes one cycle after a request is sampled. A non-reset entry then gives one strobe per cycle in the order mode, link, saved-status, status, program counter. A reset entry gives mode, status, program counter.
- R10: `entry_done` is high for exactly the program counter cycle of each entry.
- R11: A reset request sampled during a non-reset entry abandons that entry, and a reset entry's mode strobe follows in the next cycle.
- R12: After the block's own reset all strobes are low. Non-reset requests are not taken during an entry or in its program counter cycle. A level request still present afterwards is taken in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the sequencer |
| req_reset | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request, level |
| req_irq | input | 1 | Interrupt request, level |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| cur_status | input | DATA_W | Live current status word |
| ret_addr | input | ADDR_W | Return address for the link register |
| mode_wr_en | output | 1 | Mode switch strobe |
| mode_wr_val | output | 5 | New mode code |
| link_wr_en | output | 1 | Link register write strobe |
| link_wr_mode | output | 5 | Mode whose link register is written |
| link_wr_data | output | ADDR_W | Return address |
| save_wr_en | output | 1 | Saved-status write strobe |
| save_wr_mode | output | 5 | Mode whose saved-status register is written |
| save_wr_data | output | DATA_W | Old status word |
| status_wr_en | output | 1 | Current status write strobe |
| status_wr_data | output | DATA_W | Updated status word |
| pc_wr_en | output | 1 | Program counter write strobe |
| pc_wr_data | output | ADDR_W | Vector address |
| entry_done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check four things. At most one strobe is high at a time. Each strobe follows the one before it in the order of R9. Every status write has bit 7 set, bit 5 cleared and the mode field of the entry (bit 6 as well for fast interrupts). A mode switch into interrupt or fast interrupt mode never follows a sample in which that interrupt was disabled. Some behaviours show only in the bench's scenarios, where a behavioural model is compared on every clock: which request wins a collision, the exact vector and saved words, reset cutting short a running entry, and a held level request being taken only after the current entry ends.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam int MODE_W  = 5;
  localparam int NUM_EXC = 7;
  localparam int BIT_T   = 5;
  localparam int BIT_F   = 6;
  localparam int BIT_I   = 7;

  // Code value is the arbitration rank: lower code wins.
  typedef enum logic [2:0] {
    EX_RESET = 3'd0,
    EX_DABT  = 3'd1,
    EX_FIQ   = 3'd2,
    EX_IRQ   = 3'd3,
    EX_PABT  = 3'd4,
    EX_UND   = 3'd5,
    EX_SWI   = 3'd6,
    EX_NONE  = 3'd7
  } exc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MODE, ST_LINK, ST_SAVE, ST_CTRL, ST_VECT
  } seq_e;

  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;

  function automatic logic [MODE_W-1:0] target_mode(exc_e e);
    case (e)
      EX_FIQ:           return M_FIQ;
      EX_IRQ:           return M_IRQ;
      EX_DABT, EX_PABT: return M_ABT;
      EX_UND:           return M_UND;
      default:          return M_SVC;
    endcase
  endfunction

  function automatic logic [4:0] vec_offset(exc_e e);
    case (e)
      EX_UND:  return 5'h04;
      EX_SWI:  return 5'h08;
      EX_PABT: return 5'h0C;
      EX_DABT: return 5'h10;
      EX_IRQ:  return 5'h18;
      EX_FIQ:  return 5'h1C;
      default: return 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_seq_pkg::*;
#(
  parameter int NUM = NUM_EXC
) (
  input  logic [NUM-1:0] req_raw,
  input  logic           irq_off,
  input  logic           fiq_off,
  output logic           hit,
  output exc_e           win
);
  logic [NUM-1:0] live;

  always_comb begin
    live = req_raw;
    live[EX_IRQ] = req_raw[EX_IRQ] & ~irq_off;
    live[EX_FIQ] = req_raw[EX_FIQ] & ~fiq_off;
  end

  // Scan from lowest rank upward so the lowest set index is kept.
  always_comb begin
    win = EX_NONE;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (live[i]) win = exc_e'(3'(i));
    end
  end

  assign hit = |live;
endmodule

// File: rtl/exc_word_builder.sv
module exc_word_builder
  import exc_seq_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 32,
  parameter int unsigned VECTOR_BASE = 0
) (
  input  exc_e              cause,
  input  logic [DATA_W-1:0] old_stat,
  output logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] new_stat,
  output logic [ADDR_W-1:0] vector
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(VECTOR_BASE);

  always_comb begin
    mode                 = target_mode(cause);
    new_stat             = old_stat;
    new_stat[MODE_W-1:0] = mode;
    new_stat[BIT_T]      = 1'b0;
    new_stat[BIT_I]      = 1'b1;
    if (cause == EX_FIQ || cause == EX_RESET) new_stat[BIT_F] = 1'b1;
    vector = BASE + ADDR_W'(vec_offset(cause));
  end
endmodule

// File: rtl/exc_step_ctrl.sv
module exc_step_ctrl
  import exc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic req_reset,
  input  logic cur_is_reset,
  output logic load,
  output logic stb_mode,
  output logic stb_link,
  output logic stb_save,
  output logic stb_stat,
  output logic stb_pc
);
  seq_e state, nxt;

  always_comb begin
    nxt  = state;
    load = 1'b0;
    case (state)
      ST_IDLE: if (hit) begin nxt = ST_MODE; load = 1'b1; end
      ST_MODE: nxt = cur_is_reset ? ST_CTRL : ST_LINK;
      ST_LINK: nxt = ST_SAVE;
      ST_SAVE: nxt = ST_CTRL;
      ST_CTRL: nxt = ST_VECT;
      default: nxt = ST_IDLE;
    endcase
    if (state != ST_IDLE && req_reset && !cur_is_reset) begin
      nxt  = ST_MODE;
      load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      stb_mode <= 1'b0;
      stb_link <= 1'b0;
      stb_save <= 1'b0;
      stb_stat <= 1'b0;
      stb_pc   <= 1'b0;
    end else begin
      state    <= nxt;
      stb_mode <= (nxt == ST_MODE);
      stb_link <= (nxt == ST_LINK);
      stb_save <= (nxt == ST_SAVE);
      stb_stat <= (nxt == ST_CTRL);
      stb_pc   <= (nxt == ST_VECT);
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 32,
  parameter int unsigned VECTOR_BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_reset,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_und,
  input  logic              req_swi,
  input  logic [DATA_W-1:0] cur_status,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic              mode_wr_en,
  output logic [4:0]        mode_wr_val,
  output logic              link_wr_en,
  output logic [4:0]        link_wr_mode,
  output logic [ADDR_W-1:0] link_wr_data,
  output logic              save_wr_en,
  output logic [4:0]        save_wr_mode,
  output logic [DATA_W-1:0] save_wr_data,
  output logic              status_wr_en,
  output logic [DATA_W-1:0] status_wr_data,
  output logic              pc_wr_en,
  output logic [ADDR_W-1:0] pc_wr_data,
  output logic              entry_done
);
  logic [NUM_EXC-1:0] req_vec;
  logic               hit, load;
  exc_e               win, cause_q;
  logic [MODE_W-1:0]  mode_c, mode_q;
  logic [DATA_W-1:0]  new_c, new_q, old_q;
  logic [ADDR_W-1:0]  vec_c, vec_q, ret_q;
  logic               stb_pc;

  assign req_vec = {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_reset};

  exc_arbiter #(.NUM(NUM_EXC)) u_arb (
    .req_raw (req_vec),
    .irq_off (cur_status[BIT_I]),
    .fiq_off (cur_status[BIT_F]),
    .hit     (hit),
    .win     (win)
  );

  exc_word_builder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VECTOR_BASE(VECTOR_BASE)) u_build (
    .cause    (win),
    .old_stat (cur_status),
    .mode     (mode_c),
    .new_stat (new_c),
    .vector   (vec_c)
  );

  exc_step_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .hit          (hit),
    .req_reset    (req_reset),
    .cur_is_reset (cause_q == EX_RESET),
    .load         (load),
    .stb_mode     (mode_wr_en),
    .stb_link     (link_wr_en),
    .stb_save     (save_wr_en),
    .stb_stat     (status_wr_en),
    .stb_pc       (stb_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= EX_NONE;
      mode_q  <= '0;
      old_q   <= '0;
      new_q   <= '0;
      vec_q   <= '0;
      ret_q   <= '0;
    end else if (load) begin
      cause_q <= win;
      mode_q  <= mode_c;
      old_q   <= cur_status;
      new_q   <= new_c;
      vec_q   <= vec_c;
      ret_q   <= ret_addr;
    end
  end

  assign mode_wr_val    = mode_q;
  assign link_wr_mode   = mode_q;
  assign link_wr_data   = ret_q;
  assign save_wr_mode   = mode_q;
  assign save_wr_data   = old_q;
  assign status_wr_data = new_q;
  assign pc_wr_en       = stb_pc;
  assign pc_wr_data     = vec_q;
  assign entry_done     = stb_pc;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] cur_status,
  input logic              mode_wr_en,
  input logic [4:0]        mode_wr_val,
  input logic              link_wr_en,
  input logic [4:0]        link_wr_mode,
  input logic              save_wr_en,
  input logic              status_wr_en,
  input logic [DATA_W-1:0] status_wr_data,
  input logic              pc_wr_en,
  input logic [ADDR_W-1:0] pc_wr_data,
  input logic              entry_done
);
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mode_wr_en, link_wr_en, save_wr_en, status_wr_en, pc_wr_en}));
  p_link_order_r9: assert property (@(posedge clk) disable iff (rst)
    link_wr_en |-> $past(mode_wr_en));
  p_save_order_r9: assert property (@(posedge clk) disable iff (rst)
    save_wr_en |-> $past(link_wr_en));
  p_stat_order_r9: assert property (@(posedge clk) disable iff (rst)
    status_wr_en |-> ($past(save_wr_en) || $past(mode_wr_en)));
  p_pc_order_r9: assert property (@(posedge clk) disable iff (rst)
    pc_wr_en |-> $past(status_wr_en));
  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    entry_done |=> !entry_done);
  p_link_mode_r5: assert property (@(posedge clk) disable iff (rst)
    link_wr_en |-> (link_wr_mode == mode_wr_val));
  p_stat_bits_r6: assert property (@(posedge clk) disable iff (rst)
    status_wr_en |-> (status_wr_data[BIT_I] && !status_wr_data[BIT_T] &&
                      status_wr_data[4:0] == mode_wr_val));
  p_fiq_fbit_r7: assert property (@(posedge clk) disable iff (rst)
    (status_wr_en && mode_wr_val == M_FIQ) |-> status_wr_data[BIT_F]);
  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    pc_wr_en |-> (pc_wr_data[1:0] == 2'b00));
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_en && mode_wr_val == M_IRQ && !$past(rst)) |-> !$past(cur_status[BIT_I]));
  p_fiq_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_wr_en && mode_wr_val == M_FIQ && !$past(rst)) |-> !$past(cur_status[BIT_F]));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cur_status     (cur_status),
  .mode_wr_en     (mode_wr_en),
  .mode_wr_val    (mode_wr_val),
  .link_wr_en     (link_wr_en),
  .link_wr_mode   (link_wr_mode),
  .save_wr_en     (save_wr_en),
  .status_wr_en   (status_wr_en),
  .status_wr_data (status_wr_data),
  .pc_wr_en       (pc_wr_en),
  .pc_wr_data     (pc_wr_data),
  .entry_done     (entry_done)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  reqs = '0;
  logic [31:0] cur_status = 32'h0000_0010;
  logic [31:0] ret_addr = '0;
  logic        mode_wr_en, link_wr_en, save_wr_en, status_wr_en, pc_wr_en, entry_done;
  logic [4:0]  mode_wr_val, link_wr_mode, save_wr_mode;
  logic [31:0] link_wr_data, save_wr_data, status_wr_data, pc_wr_data;
  int          n_chk = 0, n_err = 0;
  string       scen = "R12 reset state";

  always #5 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst),
    .req_reset(reqs[0]), .req_dabt(reqs[1]), .req_fiq(reqs[2]), .req_irq(reqs[3]),
    .req_pabt(reqs[4]), .req_und(reqs[5]), .req_swi(reqs[6]),
    .cur_status(cur_status), .ret_addr(ret_addr),
    .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
    .link_wr_en(link_wr_en), .link_wr_mode(link_wr_mode), .link_wr_data(link_wr_data),
    .save_wr_en(save_wr_en), .save_wr_mode(save_wr_mode), .save_wr_data(save_wr_data),
    .status_wr_en(status_wr_en), .status_wr_data(status_wr_data),
    .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data), .entry_done(entry_done)
  );

  // Behavioural reference: a queue of pending step codes
  // (1 mode, 2 link, 3 saved, 4 status, 5 pc); the head is what shows now.
  int          q[$];
  int          e_cause = -1;
  logic [4:0]  e_mode;
  logic [31:0] e_old, e_new, e_vec, e_ret;

  function automatic int pick();
    if (reqs[0]) return 0;
    if (reqs[1]) return 1;
    if (reqs[2] && !cur_status[6]) return 2;
    if (reqs[3] && !cur_status[7]) return 3;
    if (reqs[4]) return 4;
    if (reqs[5]) return 5;
    if (reqs[6]) return 6;
    return -1;
  endfunction

  task automatic start(int c);
    e_cause = c;
    case (c)
      0: begin e_mode = 5'b10011; e_vec = 32'h00; end
      1: begin e_mode = 5'b10111; e_vec = 32'h10; end
      2: begin e_mode = 5'b10001; e_vec = 32'h1C; end
      3: begin e_mode = 5'b10010; e_vec = 32'h18; end
      4: begin e_mode = 5'b10111; e_vec = 32'h0C; end
      5: begin e_mode = 5'b11011; e_vec = 32'h04; end
      default: begin e_mode = 5'b10011; e_vec = 32'h08; end
    endcase
    e_old = cur_status;
    e_ret = ret_addr;
    e_new = {cur_status[31:8], 1'b1, (cur_status[6] | c == 0 | c == 2), 1'b0, e_mode};
    if (c == 0) q = '{1, 4, 5};
    else q = '{1, 2, 3, 4, 5};
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      e_cause = -1;
    end else if (q.size() > 0) begin
      if (reqs[0] && e_cause != 0) start(0);
      else void'(q.pop_front());
    end else begin
      int c;
      c = pick();
      if (c >= 0) start(c);
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: %s actual %h expected %h", scen, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int s;
      s = (q.size() > 0) ? q[0] : 0;
      chk("R9 strobes", {27'd0, mode_wr_en, link_wr_en, save_wr_en, status_wr_en, pc_wr_en},
          {27'd0, s == 1, s == 2, s == 3, s == 4, s == 5});
      chk("R10 done", {31'd0, entry_done}, {31'd0, s == 5});
      if (s == 1) chk("R3 mode", {27'd0, mode_wr_val}, {27'd0, e_mode});
      if (s == 2) chk("R5 link", link_wr_data, e_ret);
      if (s == 2) chk("R5 link mode", {27'd0, link_wr_mode}, {27'd0, e_mode});
      if (s == 3) chk("R4 saved", save_wr_data, e_old);
      if (s == 3) chk("R4 saved mode", {27'd0, save_wr_mode}, {27'd0, e_mode});
      if (s == 4) chk("R6 R7 status", status_wr_data, e_new);
      if (s == 5) chk("R2 vector", pc_wr_data, e_vec);
    end
  end

  task automatic fire(logic [6:0] r, logic [31:0] st, logic [31:0] ra, int hold, string s);
    @(negedge clk);
    scen = s; reqs = r; cur_status = st; ret_addr = ra;
    repeat (hold) @(negedge clk);
    reqs = '0;
    repeat (9) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset strobes", {27'd0, mode_wr_en, link_wr_en, save_wr_en, status_wr_en, pc_wr_en}, '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    fire(7'b0000010, 32'h0000_0010, 32'h100, 1, "R3 data abort alone");
    fire(7'b0000100, 32'h0000_0010, 32'h104, 1, "R7 fast interrupt");
    fire(7'b0001000, 32'hA000_0030, 32'h208, 1, "R6 interrupt from 16-bit state");
    fire(7'b0010000, 32'h0000_0010, 32'h30C, 1, "R2 prefetch abort");
    fire(7'b0100000, 32'h4000_0010, 32'h404, 1, "R2 undefined");
    fire(7'b1000000, 32'h0000_0010, 32'h508, 1, "R3 software interrupt");
    fire(7'b0000001, 32'h2000_0030, 32'h600, 1, "R9 reset entry");
    fire(7'b0000110, 32'h0000_0010, 32'h700, 1, "R1 data abort over fast interrupt");
    fire(7'b0001100, 32'h0000_0010, 32'h704, 1, "R1 fast over normal interrupt");
    fire(7'b0011000, 32'h0000_0010, 32'h708, 1, "R1 interrupt over prefetch abort");
    fire(7'b1110000, 32'h0000_0010, 32'h70C, 1, "R1 prefetch abort over undefined");
    fire(7'b1111111, 32'h0000_0010, 32'h710, 1, "R1 all pending");
    fire(7'b0001000, 32'h0000_0090, 32'h800, 4, "R8 interrupt masked");
    fire(7'b0000100, 32'h0000_0050, 32'h804, 4, "R8 fast interrupt masked");
    fire(7'b0001100, 32'h0000_0050, 32'h808, 1, "R8 masked fast lets interrupt in");
    fire(7'b0010000, 32'h0000_00D0, 32'h80C, 1, "R8 abort not maskable");
    // Reset arriving while an abort entry is running.
    @(negedge clk);
    scen = "R11 reset preempts";
    reqs = 7'b0010000; cur_status = 32'h0000_0010; ret_addr = 32'h900;
    @(negedge clk); reqs = '0;
    @(negedge clk); @(negedge clk); reqs = 7'b0000001;
    @(negedge clk); reqs = '0;
    repeat (8) @(negedge clk);
    // Interrupt held high while a data abort entry is running.
    @(negedge clk);
    scen = "R12 level request waits";
    reqs = 7'b0000010; ret_addr = 32'hA00;
    @(negedge clk); reqs = 7'b0001000;
    repeat (8) @(negedge clk);
    reqs = '0;
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: R9 run did not end, actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule